// File: doc/BRIEF.md
# Comma word aligner

This block takes a receive stream that arrives as raw 10-bit words, one per clock, with no word boundary applied. It finds where 8b/10b symbols begin and hands out aligned 10-bit symbols, a valid flag and a symbol-lock status. Some transceivers deliver each word with its bit order reversed. For those, a configuration input set while the block is in reset mirrors every word before the search.

Each cycle the previous word and the current word form a 20-bit window. All ten bit positions in that window are compared against the seven-bit comma prefix of K28.5, in both running-disparity forms. The first match latches that offset into a barrel shifter. Further commas at the same offset confirm it and raise lock. A run of commas at some other offset drops lock and the search starts again.

Downstream PCS/MAC logic waits for lock before it interprets training sequences. Decoding, disparity checking, elastic buffering and lane deskew are done elsewhere.

Top module: `comma_word_aligner`

## Requirements
- R1: While `rst_ni` is low, `valid_o`, `lock_o` and `sym_o` are all zero.
- R2: `rev_en_i` is sampled on clock edges while `rst_ni` is low. When it was 1, every input word has bit i swapped with bit 9-i before the search. When it was 0, words are used as given.
- R3: Bit 9 of a word (after the optional reversal) is the earliest received bit. Bit 9 of `sym_o` is the first bit of the symbol, so K28.5 appears as 0x0FA in negative disparity and 0x305 in positive disparity.
- R4: A comma starting at any of the ten bit offsets is found. The offset is the number of bits by which the stream is delayed against the word boundary (0 to 9).
- R5: The search accepts both comma prefixes: 0011111 (negative disparity) and 1100000 (positive disparity), in symbol bits 9 down to 3.
- R6: A stream that holds only the symbol 0x155 never raises `valid_o` or `lock_o`.
- R7: `valid_o` is low while searching. Suppose the first comma starts in the word taken at clock edge n. The offset is then latched at edge n+2, and `valid_o` rises at edge n+3.
- R8: `lock_o` rises at the edge that processes the second comma found at the latched offset after the first one. With a comma every four words starting in word 0, that is edge 10.
- R9: While locked, four consecutive commas at an offset other than the latched one drop `lock_o`. The search then restarts, and lock is regained with the same confirmation rule.
- R10: While locked, `sym_o` carries the received symbols in order, cut at the latched offset, and the offset does not change.
- R11: Changes of `rev_en_i` while `rst_ni` is high have no effect on alignment or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Word clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rev_en_i | input | 1 | Bit-reversal configuration, taken during reset |
| data_i | input | 10 | Raw unaligned receive word |
| sym_o | output | 10 | Aligned symbol |
| valid_o | output | 1 | `sym_o` is cut at a latched offset |
| lock_o | output | 1 | Symbol lock |

## Verification
Two things can land in the same cycle. One is the fourth misaligned comma, which ends lock. The other is the search logic, which sees that same comma as a candidate. The bench provokes this by inserting three extra bits into a stream that is already locked. It then checks that lock stays up through three bad commas, is low shortly after the fourth, and comes back only after a new full confirmation. Once relocked, the bench checks that the output again contains exactly one comma of each disparity in every eight symbols.

// File: rtl/comma_align_pkg.sv
package comma_align_pkg;
  localparam int unsigned PFX_W = 7;
  localparam logic [PFX_W-1:0] COMMA_PFX_NEG = 7'b0011111;
  localparam logic [PFX_W-1:0] COMMA_PFX_POS = 7'b1100000;

  typedef enum logic [1:0] {
    ST_SEARCH = 2'd0,
    ST_VERIFY = 2'd1,
    ST_LOCKED = 2'd2
  } align_st_e;
endpackage

// File: rtl/ca_front.sv
module ca_front #(
  parameter int unsigned SYM_W = 10,
  localparam int unsigned WIN_W = 2 * SYM_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rev_en_i,
  input  logic [SYM_W-1:0] data_i,
  output logic [WIN_W-1:0] win_o,
  output logic             primed_o
);
  logic             rev_q;
  logic [SYM_W-1:0] rev_w, word_w;
  logic [SYM_W-1:0] prev_q, cur_q;
  logic [1:0]       fill_q;

  // configuration captured only while reset is held
  always_ff @(posedge clk_i) begin
    if (!rst_ni) rev_q <= rev_en_i;
  end

  for (genvar b = 0; b < SYM_W; b++) begin : g_rev
    assign rev_w[b] = data_i[SYM_W-1-b];
  end

  assign word_w = rev_q ? rev_w : data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      cur_q  <= '0;
      fill_q <= '0;
    end else begin
      prev_q <= cur_q;
      cur_q  <= word_w;
      fill_q <= {fill_q[0], 1'b1};
    end
  end

  assign win_o    = {prev_q, cur_q};
  assign primed_o = fill_q[1];

  p_rev_cfg_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> $stable(rev_q));
endmodule

// File: rtl/ca_comma_scan.sv
module ca_comma_scan
  import comma_align_pkg::*;
#(
  parameter int unsigned SYM_W = 10,
  localparam int unsigned WIN_W = 2 * SYM_W,
  localparam int unsigned OFF_W = $clog2(SYM_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIN_W-1:0] win_i,
  input  logic             primed_i,
  output logic             hit_o,
  output logic [OFF_W-1:0] hit_off_o
);
  logic [SYM_W-1:0] hits;

  for (genvar k = 0; k < SYM_W; k++) begin : g_off
    logic [PFX_W-1:0] cand;
    assign cand    = win_i[WIN_W-1-k -: PFX_W];
    assign hits[k] = primed_i && (cand == COMMA_PFX_NEG || cand == COMMA_PFX_POS);
  end

  // lowest offset wins
  always_comb begin
    hit_o     = 1'b0;
    hit_off_o = '0;
    for (int k = SYM_W - 1; k >= 0; k--) begin
      if (hits[k]) begin
        hit_o     = 1'b1;
        hit_off_o = OFF_W'(k);
      end
    end
  end

  p_hit_in_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (32'(hit_off_o) < SYM_W));
  p_no_hit_unprimed_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !primed_i |-> !hit_o);
endmodule

// File: rtl/ca_align_fsm.sv
module ca_align_fsm
  import comma_align_pkg::*;
#(
  parameter int unsigned SYM_W       = 10,
  parameter int unsigned CONFIRM_CNT = 2,
  parameter int unsigned LOSS_CNT    = 4,
  localparam int unsigned OFF_W = $clog2(SYM_W),
  localparam int unsigned MAX_C = (CONFIRM_CNT > LOSS_CNT) ? CONFIRM_CNT : LOSS_CNT,
  localparam int unsigned CNT_W = $clog2(MAX_C + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_i,
  input  logic [OFF_W-1:0] hit_off_i,
  output logic [OFF_W-1:0] off_o,
  output logic             lock_o,
  output logic             search_o
);
  align_st_e        st_q, st_d;
  logic [OFF_W-1:0] off_q, off_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             same_off;

  assign same_off = (hit_off_i == off_q);

  always_comb begin
    st_d  = st_q;
    off_d = off_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_SEARCH: if (hit_i) begin
        st_d  = ST_VERIFY;
        off_d = hit_off_i;
        cnt_d = '0;
      end
      ST_VERIFY: if (hit_i) begin
        if (!same_off) begin
          off_d = hit_off_i;
          cnt_d = '0;
        end else if (cnt_q == CNT_W'(CONFIRM_CNT - 1)) begin
          st_d  = ST_LOCKED;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_LOCKED: if (hit_i) begin
        if (same_off) begin
          cnt_d = '0;
        end else if (cnt_q == CNT_W'(LOSS_CNT - 1)) begin
          st_d  = ST_SEARCH;
          off_d = '0;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = ST_SEARCH;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_SEARCH;
      off_q <= '0;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      off_q <= off_d;
      cnt_q <= cnt_d;
    end
  end

  assign off_o    = off_q;
  assign lock_o   = (st_q == ST_LOCKED);
  assign search_o = (st_q == ST_SEARCH);

  p_lock_on_match_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> $past(hit_i && same_off));
  p_drop_on_mismatch_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lock_o) |-> $past(hit_i && !same_off));
  p_off_hold_locked_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_o && $past(lock_o)) |-> $stable(off_q));
endmodule

// File: rtl/ca_barrel.sv
module ca_barrel #(
  parameter int unsigned SYM_W = 10,
  localparam int unsigned WIN_W = 2 * SYM_W,
  localparam int unsigned OFF_W = $clog2(SYM_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIN_W-1:0] win_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic             search_i,
  output logic [SYM_W-1:0] sym_o,
  output logic             valid_o
);
  logic [WIN_W-1:0] sh;

  assign sh = win_i << off_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sym_o   <= '0;
      valid_o <= 1'b0;
    end else begin
      sym_o   <= sh[WIN_W-1 -: SYM_W];
      valid_o <= !search_i;
    end
  end

  p_valid_after_search_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(!search_i));
endmodule

// File: rtl/comma_word_aligner.sv
module comma_word_aligner #(
  parameter int unsigned SYM_W       = 10,
  parameter int unsigned CONFIRM_CNT = 2,
  parameter int unsigned LOSS_CNT    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rev_en_i,
  input  logic [SYM_W-1:0] data_i,
  output logic [SYM_W-1:0] sym_o,
  output logic             valid_o,
  output logic             lock_o
);
  localparam int unsigned WIN_W = 2 * SYM_W;
  localparam int unsigned OFF_W = $clog2(SYM_W);

  logic [WIN_W-1:0] win;
  logic             primed, hit, search;
  logic [OFF_W-1:0] hit_off, off;

  ca_front #(.SYM_W(SYM_W)) u_front (
    .clk_i, .rst_ni, .rev_en_i, .data_i,
    .win_o(win), .primed_o(primed)
  );

  ca_comma_scan #(.SYM_W(SYM_W)) u_scan (
    .clk_i, .rst_ni, .win_i(win), .primed_i(primed),
    .hit_o(hit), .hit_off_o(hit_off)
  );

  ca_align_fsm #(.SYM_W(SYM_W), .CONFIRM_CNT(CONFIRM_CNT), .LOSS_CNT(LOSS_CNT)) u_fsm (
    .clk_i, .rst_ni, .hit_i(hit), .hit_off_i(hit_off),
    .off_o(off), .lock_o(lock_o), .search_o(search)
  );

  ca_barrel #(.SYM_W(SYM_W)) u_barrel (
    .clk_i, .rst_ni, .win_i(win), .off_i(off), .search_i(search),
    .sym_o(sym_o), .valid_o(valid_o)
  );

  p_lock_implies_valid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o |-> valid_o);
endmodule

// File: tb/comma_word_aligner_test.sv
`timescale 1ns/1ps
module comma_word_aligner_test;
  localparam logic [9:0] K_NEG = 10'h0FA;
  localparam logic [9:0] K_POS = 10'h305;
  localparam logic [9:0] D_A   = 10'h155;
  localparam logic [9:0] D_B   = 10'h2AA;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rev_en_i = 1'b0;
  logic [9:0] data_i = '0;
  logic [9:0] sym_o;
  logic       valid_o, lock_o;

  int checks = 0, failures = 0;
  bit done = 0;

  bit bq[$];
  int frame_no, widx, slip_word;
  bit rev_tx, slip_pend, d10_only;

  always #2.5 clk = ~clk;

  comma_word_aligner uut (
    .clk_i(clk), .rst_ni, .rev_en_i, .data_i, .sym_o, .valid_o, .lock_o
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic void push_sym(input logic [9:0] s);
    for (int b = 9; b >= 0; b--) bq.push_back(s[b]);
  endfunction

  function automatic void refill();
    if (d10_only) begin
      for (int j = 0; j < 4; j++) push_sym(D_A);
    end else begin
      if (slip_pend) begin
        bq.push_back(1'b1); bq.push_back(1'b0); bq.push_back(1'b1);
        slip_pend = 0;
        slip_word = widx;
      end
      push_sym(frame_no % 2 == 0 ? K_NEG : K_POS);
      push_sym(D_A); push_sym(D_B); push_sym(D_A);
      frame_no++;
    end
  endfunction

  function automatic logic [9:0] next_word();
    logic [9:0] w;
    while (bq.size() < 10) refill();
    for (int b = 9; b >= 0; b--) w[b] = bq.pop_front();
    if (rev_tx) begin
      logic [9:0] r;
      for (int b = 0; b < 10; b++) r[b] = w[9-b];
      w = r;
    end
    widx++;
    return w;
  endfunction

  task automatic start(input bit rev, input int shift, input bit only_d);
    rst_ni = 1'b0;
    rev_en_i = rev;
    rev_tx = rev;
    d10_only = only_d;
    slip_pend = 0;
    slip_word = 100000;
    bq.delete();
    frame_no = 0;
    widx = 0;
    data_i = '0;
    for (int j = 0; j < shift; j++) bq.push_back(j % 2 == 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  // check a run of 8 locked outputs: one comma of each disparity, data otherwise
  task automatic chk_run(input string req, input logic [9:0] s, inout int nneg, inout int npos);
    if (s == K_NEG) nneg++;
    else if (s == K_POS) npos++;
    else chk(req, (s == D_A || s == D_B) ? 1 : 0, 1);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 valid", valid_o, 0);
    chk("R1 lock", lock_o, 0);
    chk("R1 sym", sym_o, 0);
  endtask

  task automatic t_align(input bit rev, input int shift, input bit toggle_cfg);
    int nneg = 0, npos = 0;
    start(rev, shift, 0);
    if (toggle_cfg) rev_en_i = ~rev;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (i == 3)  chk($sformatf("R7 valid low s=%0d", shift), valid_o, 0);
      if (i == 4)  chk($sformatf("R7 valid high s=%0d", shift), valid_o, 1);
      if (i == 10) chk($sformatf("R8 lock early s=%0d", shift), lock_o, 0);
      if (i == 11) chk($sformatf("R8 lock s=%0d rev=%0d", shift, rev), lock_o, 1);
      if (i >= 12) chk_run("R10 symbol", sym_o, nneg, npos);
      if (toggle_cfg && i == 8) rev_en_i = rev;
      data_i = next_word();
    end
    // R3 R4 R5 R2 (R11 when toggled): aligned commas of both disparities
    chk($sformatf("R5 neg comma s=%0d rev=%0d", shift, rev), nneg, 1);
    chk($sformatf("R4 pos comma s=%0d rev=%0d", shift, rev), npos, 1);
    if (toggle_cfg) chk("R11 lock kept", lock_o, 1);
  endtask

  task automatic t_d10_only();
    int bad = 0;
    start(0, 4, 1);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (valid_o || lock_o) bad++;
      data_i = next_word();
    end
    chk("R6 no alignment on D10.2", bad, 0);
  endtask

  task automatic t_loss();
    int nneg = 0, npos = 0;
    start(0, 2, 0);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (i == 15) chk("R9 locked before slip", lock_o, 1);
      if (i == slip_word + 12) chk("R9 lock held over 3 bad commas", lock_o, 1);
      if (i == slip_word + 18) chk("R9 lock dropped", lock_o, 0);
      if (i == slip_word + 44) chk("R9 relock", lock_o, 1);
      if (i >= slip_word + 44 && i < slip_word + 52) chk_run("R9 realigned", sym_o, nneg, npos);
      if (i == 16) slip_pend = 1;
      data_i = next_word();
    end
    chk("R9 neg after relock", nneg, 1);
    chk("R9 pos after relock", npos, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_align(0, 0, 0);
    t_align(0, 3, 0);
    t_align(0, 7, 0);
    t_align(1, 3, 0);   // R2
    t_align(1, 9, 1);   // R2, R11
    t_d10_only();
    t_loss();
    t_reset();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule